// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM of 8,192 bytes. The RAM has an active-low chip select, an active-high second select, an active-low output enable and an active-low write strobe. On the user side there is a valid/ready request port carrying an address, a direction flag and write data. Each read returns one byte with a single-cycle valid pulse.

All RAM timing is expressed in nanoseconds as parameters. Package functions turn these into whole clock counts, rounding up. A seven-state sequencer walks each access through its phases, and one shared down-counter times every phase. The memory stays deselected whenever the controller is idle. After every read, the controller holds off for a bus-release interval, so it never drives the data pins while the RAM may still be driving them.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress: `req_ready`=1, `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access ends. Address, direction (`req_write`=1 means write) and write data are captured at that edge, and later changes to them have no effect on the access.
- R3: During a read the RAM is selected with `mem_oe_n`=0 and `mem_we_n`=1. `rsp_valid` is high for exactly one cycle and is seen RD_CYC cycles after the accepting edge, where RD_CYC = ceil(max(T_AA_NS, T_OE_NS)/CLK_NS).
- R4: `rsp_rdata` is the byte the RAM presents at the end of the read wait, which is the value most recently written to that address.
- R5: A write first spends one cycle with the address and data driven and `mem_we_n`=1. It then holds `mem_we_n`=0 for WP_CYC = ceil(max(T_WP_NS, T_DW_NS, T_AW_NS)/CLK_NS) cycles, with the address and data stable and the RAM selected.
- R6: `mem_dq_oe` is 1 only during the write setup cycle and the write strobe, and never while `mem_oe_n` is 0.
- R7: After a read, the RAM is deselected and the controller waits TA_CYC = ceil(T_HZ_NS/CLK_NS) more cycles before it is ready again. The data bus is not driven within T_HZ_NS of the output enable being released.
- R8: A write occupies 1+WP_CYC+REC_CYC cycles, where REC_CYC = max(1, ceil(T_RC_NS/CLK_NS)-1-WP_CYC). A read occupies RD_CYC+1+TA_CYC cycles. Occupancy is counted as the cycles with `req_ready`=0.
- R9: Every address from 0 to 8191 and every 8-bit data value can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 13 | RAM address bus |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_ce2 | output | 1 | RAM second select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Data to drive onto the RAM data bus |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Data sampled from the RAM data bus |

## Verification
A sequencer stuck in or skipping a phase shows up at once as a wrong `req_ready` occupancy count, measured on the first access that uses that phase. A read wait that is too short samples the bus before the timed memory model has valid data, so the very next response carries a wrong byte. A missing release wait or a badly decoded driver enable is caught in the same cycle by the bus-release timestamp in the model. A captured field that is not held shows up on the following response, or in the model's address-stability check during the strobe.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int unsigned SRAM_ADDR_W = 13;
    localparam int unsigned SRAM_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_READ_DONE,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_RECOVER,
        ST_TURNAROUND
    } ctl_state_e;

    // Strobes presented to the RAM; all derived from the sequencer state.
    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } mem_ctl_t;

    localparam mem_ctl_t MEM_CTL_IDLE = '{ce_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Whole clock cycles covering ns, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        int unsigned b;
        b = 1;
        while ((1 << b) <= v) b++;
        return b;
    endfunction

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC  = 4,
    parameter int unsigned WP_CYC  = 3,
    parameter int unsigned REC_CYC = 1,
    parameter int unsigned TA_CYC  = 3,
    parameter int unsigned CW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          acc_write,
    input  logic          cnt_zero,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          ready,
    output logic          sample_rd,
    output mem_ctl_t      ctl
);
    localparam logic [CW-1:0] RD_LOAD  = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WP_LOAD  = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] TA_LOAD  = CW'(TA_CYC - 1);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (acc_write) begin
                        state_d = ST_WRITE_SETUP;
                    end else begin
                        state_d  = ST_READ_WAIT;
                        cnt_load = 1'b1;
                        cnt_val  = RD_LOAD;
                    end
                end
            end
            ST_READ_WAIT: if (cnt_zero) state_d = ST_READ_DONE;
            ST_READ_DONE: begin
                state_d  = ST_TURNAROUND;
                cnt_load = 1'b1;
                cnt_val  = TA_LOAD;
            end
            ST_TURNAROUND: if (cnt_zero) state_d = ST_IDLE;
            ST_WRITE_SETUP: begin
                state_d  = ST_WRITE_PULSE;
                cnt_load = 1'b1;
                cnt_val  = WP_LOAD;
            end
            ST_WRITE_PULSE: begin
                if (cnt_zero) begin
                    state_d  = ST_WRITE_RECOVER;
                    cnt_load = 1'b1;
                    cnt_val  = REC_LOAD;
                end
            end
            ST_WRITE_RECOVER: if (cnt_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = MEM_CTL_IDLE;
        unique case (state_q)
            ST_READ_WAIT: begin
                ctl.ce_n = 1'b0;
                ctl.ce2  = 1'b1;
                ctl.oe_n = 1'b0;
            end
            ST_WRITE_SETUP: begin
                ctl.ce_n  = 1'b0;
                ctl.ce2   = 1'b1;
                ctl.dq_oe = 1'b1;
            end
            ST_WRITE_PULSE: begin
                ctl.ce_n  = 1'b0;
                ctl.ce2   = 1'b1;
                ctl.we_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            default: ctl = MEM_CTL_IDLE;
        endcase
    end

    assign ready     = (state_q == ST_IDLE);
    assign sample_rd = (state_q == ST_READ_WAIT) && cnt_zero;
endmodule

// File: rtl/sram_xfer_path.sv
module sram_xfer_path #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample_rd,
    input  logic [DATA_W-1:0] dq_in,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rsp_valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            write_q     <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            rdata_q     <= '0;
            rsp_valid_q <= 1'b0;
        end else begin
            if (accept) begin
                write_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample_rd) rdata_q <= dq_in;
            rsp_valid_q <= sample_rd;
        end
    end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = SRAM_ADDR_W,
    parameter int unsigned DATA_W  = SRAM_DATA_W,
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_AA_NS = 35,
    parameter int unsigned T_OE_NS = 25,
    parameter int unsigned T_WP_NS = 25,
    parameter int unsigned T_DW_NS = 20,
    parameter int unsigned T_AW_NS = 30,
    parameter int unsigned T_HZ_NS = 25,
    parameter int unsigned T_RC_NS = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC  = ns_to_cycles(max2(T_AA_NS, T_OE_NS), CLK_NS);
    localparam int unsigned WP_CYC  = ns_to_cycles(max2(T_WP_NS, max2(T_DW_NS, T_AW_NS)), CLK_NS);
    localparam int unsigned WC_CYC  = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC - 1) : 1;
    localparam int unsigned TA_CYC  = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, TA_CYC));
    localparam int unsigned CW      = bits_for(MAX_CYC);

    logic          accept;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    logic          sample_rd;
    logic          write_q;
    mem_ctl_t      ctl;

    assign accept = req_valid && req_ready;

    sram_wait_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_ctl_fsm #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .REC_CYC(REC_CYC),
        .TA_CYC (TA_CYC),
        .CW     (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .acc_write(req_write),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .ready    (req_ready),
        .sample_rd(sample_rd),
        .ctl      (ctl)
    );

    sram_xfer_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .sample_rd  (sample_rd),
        .dq_in      (mem_dq_in),
        .write_q    (write_q),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_out),
        .rdata_q    (rsp_rdata),
        .rsp_valid_q(rsp_valid)
    );

    logic unused_write_q;
    assign unused_write_q = write_q;

    assign mem_ce_n  = ctl.ce_n;
    assign mem_ce2   = ctl.ce2;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.dq_oe;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_HZ_NS = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    localparam int unsigned TA_CYC = ns_to_cycles(T_HZ_NS, CLK_NS);

    // Cycles since the RAM output enable was last low, saturating.
    logic [7:0] since_oe;
    always_ff @(posedge clk) begin
        if (rst)                  since_oe <= 8'hFF;
        else if (!mem_oe_n)       since_oe <= 8'h00;
        else if (since_oe != 8'hFF) since_oe <= since_oe + 8'h01;
    end

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst) req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R2
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R3
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $past(!mem_oe_n)); // R3
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n && mem_ce2)); // R5
    AST_WE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R5
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> mem_oe_n); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> (since_oe >= 8'(TA_CYC))); // R7
endmodule

bind async_sram_ctl sram_ctl_chk #(
    .ADDR_W (ADDR_W),
    .CLK_NS (CLK_NS),
    .T_HZ_NS(T_HZ_NS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_ce2  (mem_ce2),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_async_sram_ctl.sv
`timescale 1ns/1ps
module test_async_sram_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int T_AA = 35, T_OE = 25, T_WP = 25, T_DW = 20, T_AW = 30, T_HZ = 25, T_RC = 35;
    localparam int WSTROBE_NS  = (T_WP > T_DW ? (T_WP > T_AW ? T_WP : T_AW) : (T_DW > T_AW ? T_DW : T_AW));
    localparam int EXP_RD      = ((T_AA > T_OE ? T_AA : T_OE) + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP      = (WSTROBE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_TA      = (T_HZ + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WC      = (T_RC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_REC     = (EXP_WC - 1 - EXP_WP) > 1 ? (EXP_WC - 1 - EXP_WP) : 1;
    localparam int EXP_WR_BUSY = 1 + EXP_WP + EXP_REC;
    localparam int EXP_RD_BUSY = EXP_RD + 1 + EXP_TA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [12:0] req_addr = '0, mem_addr;
    logic [7:0]  req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in;
    logic        rsp_valid, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_sram_ctl #(.CLK_NS(CLK_PERIOD)) i_async_sram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- timed RAM model ----------------
    logic [7:0] ram [int];
    logic [7:0] shadow [int];
    longint t_rd_start = 0, t_rd_end = -1000, t_we_fall = 0;
    bit     rd_prev = 1'b0, we_prev = 1'b1;
    logic [12:0] pend_addr = '0;
    logic [7:0]  pend_data = '0;
    bit          pend_ok = 1'b0;

    function automatic logic [7:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction

    always @(mem_ce_n or mem_ce2 or mem_oe_n or mem_we_n) begin
        bit rd_now;
        rd_now = !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n;
        if (rd_now && !rd_prev) t_rd_start = longint'($time);
        if (!rd_now && rd_prev) t_rd_end = longint'($time);
        rd_prev = rd_now;
        if (!mem_we_n && we_prev) begin
            t_we_fall = longint'($time);
            pend_ok = 1'b0;
        end
        if (mem_we_n && !we_prev) begin
            chk(longint'($time) - t_we_fall >= WSTROBE_NS, "R5 strobe width ns",
                int'(longint'($time) - t_we_fall), WSTROBE_NS);
            chk(pend_ok, "R5 data driven during strobe", int'(pend_ok), 1);
            if (pend_ok) ram[int'(pend_addr)] = pend_data;
        end
        we_prev = mem_we_n;
    end

    always @(negedge clk) begin
        if (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n && (longint'($time) - t_rd_start >= T_AA))
            mem_dq_in <= ram_rd(int'(mem_addr));
        else
            mem_dq_in <= 8'hEE;
        if (!rst && !mem_we_n) begin
            if (pend_ok) chk(mem_addr == pend_addr && mem_dq_out == pend_data, "R5 addr/data stable",
                             int'(mem_addr), int'(pend_addr));
            pend_ok   = mem_dq_oe && !mem_ce_n && mem_ce2;
            pend_addr = mem_addr;
            pend_data = mem_dq_out;
        end
        if (!rst && mem_dq_oe) begin
            chk(longint'($time) - t_rd_end >= T_HZ, "R7 bus release time",
                int'(longint'($time) - t_rd_end), T_HZ);
            chk(mem_oe_n, "R6 drive while oe low", int'(mem_oe_n), 1);
        end
        if (!rst && req_ready)
            chk(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle deselect",
                int'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}), 5'b10110);
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q [$];
    int         acc_q [$];
    bit         rsp_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                chk(!rsp_prev, "R3 single-cycle valid", int'(rsp_prev), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected response", 1, 0);
                end else begin
                    logic [7:0] e;
                    int a;
                    e = exp_q.pop_front();
                    a = acc_q.pop_front();
                    chk(rsp_rdata == e, "R4 read data", int'(rsp_rdata), int'(e));
                    chk(cyc - a == EXP_RD, "R3 read latency", cyc - a, EXP_RD);
                end
            end
            rsp_prev = rsp_valid;
        end
    end

    task automatic do_req(input bit wr, input int addr, input int data);
        int busy;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 13'(addr);
        req_wdata = 8'(data);
        @(posedge clk);
        #1;
        if (!wr) begin
            exp_q.push_back(shadow.exists(addr) ? shadow[addr] : 8'h00);
            acc_q.push_back(cyc);
        end else begin
            shadow[addr] = 8'(data);
        end
        // R2: scramble the request fields once accepted
        req_valid = 1'b0;
        req_write = !wr;
        req_addr  = ~13'(addr);
        req_wdata = ~8'(data);
        busy = 0;
        @(negedge clk);
        chk(!req_ready, "R2 ready drops after accept", int'(req_ready), 0);
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        chk(busy == (wr ? EXP_WR_BUSY : EXP_RD_BUSY), wr ? "R8 write occupancy" : "R8 read occupancy",
            busy, wr ? EXP_WR_BUSY : EXP_RD_BUSY);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready && mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
            "R1 reset state", int'({req_ready, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}),
            7'b1101100);
        // R9 boundary addresses and extreme data
        do_req(1'b1, 0, 8'h00);
        do_req(1'b1, 8191, 8'hFF);
        do_req(1'b1, 1, 8'hA5);
        do_req(1'b1, 8190, 8'h5A);
        do_req(1'b0, 0, 0);
        do_req(1'b0, 8191, 0);
        do_req(1'b0, 1, 0);
        do_req(1'b0, 8190, 0);
        // scattered pattern
        for (int i = 0; i < 16; i++) do_req(1'b1, (i * 509 + 3) % 8192, i * 37 + 1);
        for (int i = 15; i >= 0; i--) do_req(1'b0, (i * 509 + 3) % 8192, 0);
        // overwrite then read, alternating read/write turnarounds (R7)
        do_req(1'b1, 100, 8'h11);
        do_req(1'b1, 100, 8'h22);
        do_req(1'b0, 100, 0);
        for (int i = 0; i < 6; i++) begin
            do_req(1'b1, 4096 + i, 8'hC0 + i);
            do_req(1'b0, 4096 + i, 0);
        end
        do_req(1'b0, 100, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule